// File: doc/BRIEF.md
# Signed Register-Mapped Divider

This block is a divide unit that a processor drives through a small 32-bit register port. Software first stores a divisor, then stores a dividend; that second store launches a signed 32-by-32 division. While the division runs, the dividend also appears in a 64-bit pair of read-only registers. The low register holds the written value. The high register holds that value's sign bit copied across all 32 bits.

The divider is iterative and produces one quotient bit per clock. When it finishes, the truncated quotient replaces the dividend and the low register, and the remainder goes to the high register. Two cases cannot be represented: a zero divisor, and the most negative dividend divided by minus one. In either case the quotient saturates and a sticky overflow flag is raised. That flag, gated by an enable bit in the control register, drives an interrupt request. The divisor register is never altered by an operation.

Register map, by word address: 0 divisor, 1 control (bit 1 interrupt enable, bit 0 overflow flag), 2 dividend (a write launches a division), 3 high half, 4 low half. Addresses 5 to 7 are unmapped.

Top module: `sgn_div_unit`

## Requirements
- R1: After a synchronous reset, `busy`, `irq` and `bus_rdata` are 0, and the control register reads 0.
- R2: A write to address 2 with all four byte enables set, made while idle, raises `busy` from the next cycle for exactly 33 cycles. During that time address 4 reads the written value and address 3 reads its bit 31 replicated across all 32 bits.
- R3: When `busy` falls, addresses 2 and 4 read the quotient truncated toward zero, and address 3 reads the remainder, whose sign follows the dividend. The divisor at address 0 is unchanged.
- R4: A zero divisor sets the overflow flag. The quotient becomes 0x7FFFFFFF for a non-negative dividend and 0x80000000 for a negative one, and the remainder equals the dividend.
- R5: Dividing 0x80000000 by 0xFFFFFFFF sets the overflow flag, gives the quotient 0x7FFFFFFF and gives the remainder 0.
- R6: The overflow flag (control bit 0) is cleared only by a control write with bit 0 equal to 0. Writing 1 to it has no effect. A hardware set in the same cycle as a clearing write leaves the flag at 1.
- R7: `irq` is 1 exactly when both control bit 1 (enable) and control bit 0 (flag) are 1.
- R8: Control bits 31 to 2 always read 0. A control write takes effect only when byte enable 0 is set, so a 16-bit write to the low half works.
- R9: A write to address 0 or 2 without all four byte enables is ignored, and does not start a division.
- R10: While `busy` is 1, writes to addresses 0 and 2 are ignored, and reads return the contents held before the division finished.
- R11: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read. Addresses 5 to 7 read 0, and writes to addresses 3 and 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address of the register |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| busy | output | 1 | Division in progress |
| irq | output | 1 | Overflow interrupt request |

## Verification
Two events can fall in the same cycle: the hardware setting the overflow flag at write-back, and a software control write that clears it. The bench starts a zero-divisor division and times a clearing control write to land on the write-back edge. It judges the result by reading the control register back and by watching `irq`. A second collision is a read of the result registers on the write-back edge itself; it must return the pre-division contents. A behavioural model predicts both collisions, and every clock the bench compares the model's busy, interrupt and read data with the design's.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  // word addresses of the register port
  typedef enum logic [2:0] {
    ADR_DVS  = 3'd0,
    ADR_CTRL = 3'd1,
    ADR_DVD  = 3'd2,
    ADR_HI   = 3'd3,
    ADR_LO   = 3'd4
  } addr_e;

  // control register bit positions
  localparam int CTL_OVF = 0;
  localparam int CTL_IE  = 1;
endpackage

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dvd_i,
  input  logic [W-1:0] dvs_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] quo_o,
  output logic [W-1:0] rem_o,
  output logic         ovf_o
);
  localparam int CW = (W > 2) ? $clog2(W) : 1;
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = ~MIN_V;
  localparam logic [W-1:0] ALL1  = {W{1'b1}};

  logic [CW-1:0] cnt;
  logic          run_q, done_q;
  logic          qneg_q, rneg_q, ovf_q;
  logic [W-1:0]  rem_q, quo_q, mag_q;
  logic [W-1:0]  res_quo_q, res_rem_q;

  logic [W:0]    shifted, trial;
  logic          take, last, ovf_now;
  logic [W-1:0]  nrem, nquo, dvd_mag, dvs_mag;

  always_comb begin
    shifted = {rem_q, quo_q[W-1]};
    trial   = shifted - {1'b0, mag_q};
    take    = ~trial[W];
    nrem    = take ? trial[W-1:0] : shifted[W-1:0];
    nquo    = {quo_q[W-2:0], take};
    last    = (cnt == CW'(W-1));
    dvd_mag = dvd_i[W-1] ? ((~dvd_i) + W'(1)) : dvd_i;
    dvs_mag = dvs_i[W-1] ? ((~dvs_i) + W'(1)) : dvs_i;
    ovf_now = (dvs_i == '0) | ((dvd_i == MIN_V) & (dvs_i == ALL1));
  end

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else begin
      done_q <= run_q & last;
      if (start) begin
        run_q <= 1'b1;
        cnt   <= '0;
      end else if (run_q) begin
        cnt <= cnt + CW'(1);
        if (last) run_q <= 1'b0;
      end
    end
  end

  // datapath: no reset needed
  always_ff @(posedge clk) begin
    if (start) begin
      rem_q  <= '0;
      quo_q  <= dvd_mag;
      mag_q  <= dvs_mag;
      qneg_q <= dvd_i[W-1] ^ dvs_i[W-1];
      rneg_q <= dvd_i[W-1];
      ovf_q  <= ovf_now;
    end else if (run_q) begin
      rem_q <= nrem;
      quo_q <= nquo;
      if (last) begin
        if (ovf_q)       res_quo_q <= qneg_q ? MIN_V : MAX_V;
        else if (qneg_q) res_quo_q <= (~nquo) + W'(1);
        else             res_quo_q <= nquo;
        res_rem_q <= rneg_q ? ((~nrem) + W'(1)) : nrem;
      end
    end
  end

  assign busy_o = run_q;
  assign done_o = done_q;
  assign quo_o  = res_quo_q;
  assign rem_o  = res_rem_q;
  assign ovf_o  = ovf_q;

  assert_start_runs_R2: assert property (@(posedge clk) disable iff (rst)
    start |=> run_q);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
  assert_done_idle_R2: assert property (@(posedge clk) disable iff (rst)
    done_q |-> !run_q);
  assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (rst)
    (start && dvs_i == '0) |=> ovf_q);
  assert_min_by_neg1_R5: assert property (@(posedge clk) disable iff (rst)
    (start && dvd_i == MIN_V && dvs_i == ALL1) |=> ovf_q);
endmodule

// File: rtl/sdiv_ctrl.sv
module sdiv_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic ie_wr,
  input  logic ovf_wr,
  input  logic hw_set,
  output logic ie_o,
  output logic ovf_o,
  output logic irq_o
);
  logic ie_q, ovf_q, irq_q;
  logic ie_d, ovf_d;

  always_comb begin
    ie_d  = wr_en ? ie_wr : ie_q;
    ovf_d = hw_set | (ovf_q & ~(wr_en & ~ovf_wr));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ie_q  <= 1'b0;
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      ovf_q <= ovf_d;
      irq_q <= ie_d & ovf_d;
    end
  end

  assign ie_o  = ie_q;
  assign ovf_o = ovf_q;
  assign irq_o = irq_q;

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !(wr_en && !ovf_wr)) |=> ovf_q);
  assert_write1_inert_R6: assert property (@(posedge clk) disable iff (rst)
    (!ovf_q && !hw_set) |=> !ovf_q);
  assert_hw_wins_R6: assert property (@(posedge clk) disable iff (rst)
    hw_set |=> ovf_q);
  assert_irq_needs_both_R7: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (ie_q && ovf_q));
  assert_irq_when_both_R7: assert property (@(posedge clk) disable iff (rst)
    (ie_q && ovf_q) |-> irq_q);
endmodule

// File: rtl/sgn_div_unit.sv
module sgn_div_unit
  import sdiv_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [W/8-1:0]  bus_be,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  output logic            busy,
  output logic            irq
);
  localparam logic [AW-1:0] A_DVS  = AW'(ADR_DVS);
  localparam logic [AW-1:0] A_CTRL = AW'(ADR_CTRL);
  localparam logic [AW-1:0] A_DVD  = AW'(ADR_DVD);
  localparam logic [AW-1:0] A_HI   = AW'(ADR_HI);
  localparam logic [AW-1:0] A_LO   = AW'(ADR_LO);

  logic [W-1:0] dvs_q, dvd_q, hi_q, lo_q, rdata_q;
  logic         core_busy, core_done, core_ovf;
  logic [W-1:0] core_quo, core_rem;
  logic         ctl_ie, ctl_ovf;
  logic         wr_full, dvs_we, start, ctrl_we, rd_en;

  always_comb begin
    wr_full = bus_sel & bus_wr & (&bus_be) & ~busy;
    dvs_we  = wr_full & (bus_addr == A_DVS);
    start   = wr_full & (bus_addr == A_DVD);
    ctrl_we = bus_sel & bus_wr & bus_be[0] & (bus_addr == A_CTRL);
    rd_en   = bus_sel & ~bus_wr;
  end

  sdiv_core #(.W(W)) u_core (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .dvd_i  (bus_wdata),
    .dvs_i  (dvs_q),
    .busy_o (core_busy),
    .done_o (core_done),
    .quo_o  (core_quo),
    .rem_o  (core_rem),
    .ovf_o  (core_ovf)
  );

  sdiv_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (ctrl_we),
    .ie_wr  (bus_wdata[CTL_IE]),
    .ovf_wr (bus_wdata[CTL_OVF]),
    .hw_set (core_done & core_ovf),
    .ie_o   (ctl_ie),
    .ovf_o  (ctl_ovf),
    .irq_o  (irq)
  );

  // operand and result registers: left unreset
  always_ff @(posedge clk) begin
    if (dvs_we) dvs_q <= bus_wdata;
    if (start) begin
      dvd_q <= bus_wdata;
      lo_q  <= bus_wdata;
      hi_q  <= {W{bus_wdata[W-1]}};
    end else if (core_done) begin
      dvd_q <= core_quo;
      lo_q  <= core_quo;
      hi_q  <= core_rem;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      case (bus_addr)
        A_DVS:   rdata_q <= dvs_q;
        A_CTRL:  rdata_q <= {{(W-2){1'b0}}, ctl_ie, ctl_ovf};
        A_DVD:   rdata_q <= dvd_q;
        A_HI:    rdata_q <= hi_q;
        A_LO:    rdata_q <= lo_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign busy      = core_busy | core_done;
  assign bus_rdata = rdata_q;

  assert_ctrl_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr == A_CTRL) |=> (bus_rdata[W-1:2] == '0));
  assert_partial_no_start_R9: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_wr && bus_addr == A_DVD && !(&bus_be) && !busy) |=> !busy);
  assert_divisor_kept_R3: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(dvs_q));
  assert_unmapped_zero_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_addr > A_LO) |=> (bus_rdata == '0));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(bus_rdata));
endmodule

// File: tb/test_sgn_div_unit.sv
module test_sgn_div_unit;
  localparam int LAT = 33;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        busy, irq;

  always #2.5 clk = ~clk;

  sgn_div_unit i_sgn_div_unit (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_wr(wr), .bus_addr(addr),
    .bus_be(be), .bus_wdata(wdata), .bus_rdata(rdata), .busy(busy), .irq(irq)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done_flag = 0;
  string cur_tag = "R1";

  // behavioural reference model
  logic [31:0] m_dvs, m_dvd, m_hi, m_lo, m_rd, r_q, r_r;
  bit          m_dvs_ok = 0, m_dvd_ok = 0, m_rd_ok = 0, m_started = 0;
  bit          m_ie = 0, m_ovf = 0, r_ov = 0, was_busy, hw;
  int          m_cnt = 0;
  string       m_rd_tag = "R1";

  function automatic void ref_div(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] q, output logic [31:0] r,
                                  output bit ov);
    longint sa = longint'($signed(a));
    longint sb = longint'($signed(b));
    if (sb == 0) begin
      ov = 1; q = a[31] ? 32'h8000_0000 : 32'h7FFF_FFFF; r = a;
    end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
      ov = 1; q = 32'h7FFF_FFFF; r = 32'h0;
    end else begin
      ov = 0; q = 32'(sa / sb); r = 32'(sa % sb);
    end
  endfunction

  always @(posedge clk) begin
    m_started = 1;
    was_busy  = (m_cnt > 0);
    hw        = 0;
    if (rst) begin
      m_ie = 0; m_ovf = 0; m_cnt = 0; m_rd = '0; m_rd_ok = 1; m_rd_tag = "R1";
    end else begin
      if (sel && !wr) begin
        m_rd_ok  = 1;
        m_rd_tag = cur_tag;
        case (addr)
          3'd0: begin m_rd = m_dvs; m_rd_ok = m_dvs_ok; end
          3'd1: m_rd = {30'b0, m_ie, m_ovf};
          3'd2: begin m_rd = m_dvd; m_rd_ok = m_dvd_ok; end
          3'd3: begin m_rd = m_hi;  m_rd_ok = m_dvd_ok; end
          3'd4: begin m_rd = m_lo;  m_rd_ok = m_dvd_ok; end
          default: m_rd = '0;
        endcase
      end
      if (m_cnt == 1) begin
        m_dvd = r_q; m_lo = r_q; m_hi = r_r;
        hw = r_ov;
        if (r_ov) m_ovf = 1;
      end
      if (m_cnt > 0) m_cnt--;
      if (sel && wr) begin
        if (addr == 3'd1 && be[0]) begin
          m_ie = wdata[1];
          if (!wdata[0] && !hw) m_ovf = 0;
        end
        if (!was_busy && be == 4'hF) begin
          if (addr == 3'd0) begin m_dvs = wdata; m_dvs_ok = 1; end
          if (addr == 3'd2) begin
            m_dvd = wdata; m_lo = wdata; m_hi = {32{wdata[31]}}; m_dvd_ok = 1;
            ref_div(wdata, m_dvs, r_q, r_r, r_ov);
            m_cnt = LAT;
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (m_started && !done_flag) begin
      chk("R2", {31'b0, busy}, {31'b0, (m_cnt > 0)});
      chk("R7", {31'b0, irq}, {31'b0, (m_ie & m_ovf)});
      if (m_rd_ok) chk(m_rd_tag, rdata, m_rd);
    end
  end

  task automatic bus_w(input logic [2:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk); sel = 1; wr = 1; addr = a; be = b; wdata = d;
    @(negedge clk); sel = 0; wr = 0;
  endtask

  task automatic bus_r(input logic [2:0] a, input string tag);
    @(negedge clk); cur_tag = tag; sel = 1; wr = 0; addr = a;
    @(negedge clk); sel = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic divide(input logic [31:0] a, input logic [31:0] b, input string tag);
    bus_w(3'd0, 4'hF, b);
    bus_w(3'd2, 4'hF, a);
    bus_r(3'd4, "R2");
    bus_r(3'd3, "R2");
    wait_idle();
    bus_r(3'd2, tag);
    bus_r(3'd3, tag);
    bus_r(3'd4, tag);
    bus_r(3'd0, "R3");
    bus_r(3'd1, tag);
  endtask

  task automatic summary();
    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    @(negedge clk);
    chk("R1", {31'b0, busy}, 32'h0);
    chk("R1", {31'b0, irq}, 32'h0);
    chk("R1", rdata, 32'h0);
    bus_r(3'd1, "R1");

    // R2 / R3: sign combinations
    divide(32'd100, 32'd7, "R3");
    divide(-32'sd100, 32'd7, "R3");
    divide(32'd100, -32'sd7, "R3");
    divide(-32'sd100, -32'sd7, "R3");
    divide(32'h8000_0000, 32'd3, "R3");

    // R4: zero divisor, both dividend signs
    divide(32'd55, 32'd0, "R4");
    bus_w(3'd1, 4'h1, 32'h0);
    divide(-32'sd55, 32'd0, "R4");
    bus_w(3'd1, 4'h1, 32'h0);

    // R5: most negative by minus one
    divide(32'h8000_0000, 32'hFFFF_FFFF, "R5");

    // R6: writing 1 inert, writing 0 clears
    bus_w(3'd1, 4'hF, 32'h0);
    bus_r(3'd1, "R6");
    bus_w(3'd1, 4'hF, 32'h1);
    bus_r(3'd1, "R6");
    // R6: clear lands on the write-back edge of an overflowing divide
    bus_w(3'd0, 4'hF, 32'h0);
    bus_w(3'd2, 4'hF, 32'd9);
    repeat (LAT - 2) @(negedge clk);
    bus_w(3'd1, 4'h1, 32'h0);
    wait_idle();
    bus_r(3'd1, "R6");

    // R7: enable and flag combinations
    bus_w(3'd1, 4'hF, 32'h3);
    bus_r(3'd1, "R7");
    bus_w(3'd1, 4'hF, 32'h1);
    bus_r(3'd1, "R7");
    bus_w(3'd1, 4'hF, 32'h2);
    bus_w(3'd1, 4'hF, 32'h0);
    bus_w(3'd1, 4'hF, 32'h2);
    divide(32'd1, 32'd0, "R7");
    bus_w(3'd1, 4'hF, 32'h0);

    // R8: lane 0 needed, upper bits read zero
    bus_w(3'd1, 4'hE, 32'h3);
    bus_r(3'd1, "R8");
    bus_w(3'd1, 4'h1, 32'hFFFF_FFFE);
    bus_r(3'd1, "R8");
    bus_w(3'd1, 4'h3, 32'h0);

    // R9: partial writes ignored, no start
    bus_w(3'd0, 4'hF, 32'd5);
    bus_w(3'd0, 4'h7, 32'd11);
    bus_r(3'd0, "R9");
    bus_w(3'd2, 4'h7, 32'd40);
    @(negedge clk);
    chk("R9", {31'b0, busy}, 32'h0);
    bus_r(3'd2, "R9");

    // R10: writes ignored and old contents read while busy
    bus_w(3'd0, 4'hF, 32'd3);
    bus_w(3'd2, 4'hF, 32'd50);
    bus_w(3'd0, 4'hF, 32'd9);
    bus_w(3'd2, 4'hF, 32'd77);
    bus_r(3'd2, "R10");
    bus_r(3'd0, "R10");
    wait_idle();
    bus_r(3'd2, "R10");
    bus_r(3'd3, "R10");
    // read on the write-back edge returns the pre-result value
    bus_w(3'd2, 4'hF, 32'd61);
    repeat (LAT - 2) @(negedge clk);
    bus_r(3'd2, "R10");
    wait_idle();
    bus_r(3'd2, "R10");

    // R11: unmapped reads and read-only halves
    bus_w(3'd3, 4'hF, 32'h1234_5678);
    bus_w(3'd4, 4'hF, 32'h1234_5678);
    bus_r(3'd3, "R11");
    bus_r(3'd4, "R11");
    for (int a = 5; a < 8; a++) bus_r(3'(a), "R11");

    // mixed operands
    for (int i = 0; i < 24; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = (i % 3 == 0) ? 32'($urandom % 17) - 32'd8 : $urandom;
      if (i % 5 == 0) a = a >> (i % 31);
      divide(a, b, "R3");
      bus_w(3'd1, 4'h1, 32'h0);
    end

    repeat (2) @(negedge clk);
    summary();
    $finish;
  end
endmodule